// File: doc/BRIEF.md
# Hysteretic Thermal Trip Override

This block is the hardware over-temperature safety net of a fan controller. On every conversion strobe it compares a fresh internal (ambient) reading and a fresh remote (diode) reading, both signed 8-bit degrees, against one active trip limit per channel. A channel trips after three consecutive readings strictly above its limit. It rearms only after three consecutive readings at least five degrees below that limit. The two channels keep separate hysteresis state, and the block is tripped while either channel is tripped.

Each channel has a fixed default limit (70 for internal, 100 for remote) and a programmable limit (reset values 127 for internal, 100 for remote). A write-once lock bit selects which of the two is active. While the lock is clear, the fixed defaults govern and the programmable limits can be written. Once the lock is set, the programmable limits govern and are frozen. While tripped, the block drives both active-low over-temperature outputs low, forces the fan speed code to full scale and holds the active-low fan-off request released. When the trip clears, the programmed speed code and the fan-off configuration pass through again.

Top module: `thermal_trip_override`

## Requirements
- R1: While `rst` is high, and at the first output cycle after it, `therm_a_n` and `therm_b_n` are 1, `fan_code_out` is 8'h00 and `fan_off_n` is 1. The lock is clear and the programmable limits hold their reset values (internal 127, remote 100).
- R2: While the lock is clear, the active limits are the fixed defaults: internal 70, remote 100. A programmable-limit write (`lim_wr_int` or `lim_wr_rem` with `lim_wr_data`) is accepted but has no effect on tripping.
- R3: A `cfg_wr` with `cfg_lock`=1 sets the lock, and a `cfg_wr` with `cfg_lock`=0 leaves it unchanged. While the lock is set, the programmable limits are active and writes to them are ignored. Only `rst`, `hard_rst_a` or `hard_rst_b` clears the lock. The hard resets change nothing else in the block.
- R4: A channel trips on the third consecutive strobed reading strictly greater than its active limit. A reading equal to the limit, or any reading not above it, restarts the count.
- R5: `therm_a_n` and `therm_b_n` are always equal and are low while either channel is tripped (OR of the two channels). Each channel's trip and release are independent of the other channel's.
- R6: A tripped channel releases on the third consecutive strobed reading that is less than or equal to its active limit minus 5. Any other reading restarts that count.
- R7: While tripped, `fan_code_out` is 8'hFF and `fan_off_n` is 1, whatever `fan_code_in` and `fan_off_cfg` are.
- R8: While not tripped, `fan_code_out` equals `fan_code_in` and `fan_off_n` equals the inverse of `fan_off_cfg`, one clock later. After a release this includes any speed code applied during the trip.
- R9: `soft_rst` neither clears nor rearms a trip and does not disturb the consecutive-reading counts. While the lock is clear it restores the programmable limits to their reset values. While the lock is set it has no effect.
- R10: Limits and readings are compared as signed two's-complement values.
- R11: Readings are evaluated only in cycles with `conv_stb`=1. A strobe sampled at clock edge k changes the outputs at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| hard_rst_a | input | 1 | First hard reset input, clears the lock |
| hard_rst_b | input | 1 | Second hard reset input, clears the lock |
| soft_rst | input | 1 | Soft reset, reloads unlocked programmable limits |
| conv_stb | input | 1 | One-cycle strobe marking new readings |
| temp_int | input | 8 | Internal channel reading, signed degrees |
| temp_rem | input | 8 | Remote channel reading, signed degrees |
| lim_wr_int | input | 1 | Write strobe for the internal programmable limit |
| lim_wr_rem | input | 1 | Write strobe for the remote programmable limit |
| lim_wr_data | input | 8 | Limit write data, signed degrees |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_lock | input | 1 | Lock bit value carried by a configuration write |
| fan_code_in | input | 8 | Programmed fan speed code |
| fan_off_cfg | input | 1 | 1 requests the fan off |
| therm_a_n | output | 1 | Active-low over-temperature output |
| therm_b_n | output | 1 | Second active-low over-temperature output |
| fan_code_out | output | 8 | Fan speed code after override |
| fan_off_n | output | 1 | Active-low fan-off request |

## Verification
Two functions can land on the same clock edge: the trip release, and a new programmed speed code that arrives while the override still masks it. The bench changes `fan_code_in` during a trip and then supplies the third qualifying cooling reading. The check requires `fan_code_out` to show the new code, not the pre-trip one, exactly one cycle after the release strobe. A second collision puts a soft reset between cooling readings. It is judged by the release still arriving on the third qualifying reading, with no extra reading needed.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_INT = 0;
  localparam int CH_REM = 1;

  typedef enum logic {
    ST_ARMED   = 1'b0,
    ST_TRIPPED = 1'b1
  } trip_state_e;
endpackage

// File: rtl/trip_limit_bank.sv
module trip_limit_bank #(
  parameter int TEMP_W  = 8,
  parameter int DEF_INT = 70,
  parameter int DEF_REM = 100,
  parameter int RST_INT = 127,
  parameter int RST_REM = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hard_rst_a,
  input  logic              hard_rst_b,
  input  logic              soft_rst,
  input  logic              lim_wr_int,
  input  logic              lim_wr_rem,
  input  logic [TEMP_W-1:0] lim_wr_data,
  input  logic              cfg_wr,
  input  logic              cfg_lock,
  output logic [TEMP_W-1:0] act_int,
  output logic [TEMP_W-1:0] act_rem
);
  localparam logic [TEMP_W-1:0] FIX_INT = TEMP_W'(DEF_INT);
  localparam logic [TEMP_W-1:0] FIX_REM = TEMP_W'(DEF_REM);
  localparam logic [TEMP_W-1:0] INI_INT = TEMP_W'(RST_INT);
  localparam logic [TEMP_W-1:0] INI_REM = TEMP_W'(RST_REM);

  logic              lock_q;
  logic [TEMP_W-1:0] prog_int_q;
  logic [TEMP_W-1:0] prog_rem_q;
  logic              hard_any;

  assign hard_any = hard_rst_a | hard_rst_b;

  // Write-once lock: set only by a configuration write carrying 1
  always_ff @(posedge clk) begin
    if (rst || hard_any) begin
      lock_q <= 1'b0;
    end else if (cfg_wr && cfg_lock) begin
      lock_q <= 1'b1;
    end
  end

  // Programmable limits, frozen while locked
  always_ff @(posedge clk) begin
    if (rst) begin
      prog_int_q <= INI_INT;
      prog_rem_q <= INI_REM;
    end else if (!lock_q) begin
      if (soft_rst) begin
        prog_int_q <= INI_INT;
        prog_rem_q <= INI_REM;
      end else begin
        if (lim_wr_int) prog_int_q <= lim_wr_data;
        if (lim_wr_rem) prog_rem_q <= lim_wr_data;
      end
    end
  end

  always_comb begin
    act_int = lock_q ? prog_int_q : FIX_INT;
    act_rem = lock_q ? prog_rem_q : FIX_REM;
  end

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_q) |-> $past(hard_any));

  assert_locked_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(prog_int_q) && $stable(prog_rem_q)));

  assert_soft_reload_R9: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !lock_q) |=> (prog_int_q == INI_INT && prog_rem_q == INI_REM));
endmodule

// File: rtl/trip_hysteresis.sv
module trip_hysteresis
  import thermal_trip_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int TRIP_CNT = 3,
  parameter int HYST     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_stb,
  input  logic [TEMP_W-1:0] reading,
  input  logic [TEMP_W-1:0] limit,
  output logic              tripped
);
  localparam int CW = $clog2(TRIP_CNT + 1);
  localparam int EW = TEMP_W + 2;
  localparam logic [CW-1:0] LAST = CW'(TRIP_CNT - 1);
  localparam logic signed [EW-1:0] HYST_X = EW'(HYST);

  trip_state_e       state_q;
  logic [CW-1:0]     cnt_q;
  logic signed [TEMP_W-1:0] rd_s;
  logic signed [TEMP_W-1:0] lim_s;
  logic signed [EW-1:0]     rd_x;
  logic signed [EW-1:0]     lim_x;
  logic              hot;
  logic              cool;
  logic              qualify;

  always_comb begin
    rd_s    = reading;
    lim_s   = limit;
    rd_x    = EW'(rd_s);
    lim_x   = EW'(lim_s);
    hot     = rd_s > lim_s;
    cool    = (rd_x + HYST_X) <= lim_x;
    qualify = (state_q == ST_ARMED) ? hot : cool;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARMED;
      cnt_q   <= '0;
    end else if (conv_stb) begin
      if (!qualify) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        cnt_q   <= '0;
        state_q <= (state_q == ST_ARMED) ? ST_TRIPPED : ST_ARMED;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tripped = (state_q == ST_TRIPPED);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(TRIP_CNT));

  assert_trip_needs_hot_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tripped) |-> $past(conv_stb && hot));

  assert_release_needs_cool_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(tripped) |-> $past(conv_stb && cool));

  assert_idle_without_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    !conv_stb |=> ($stable(state_q) && $stable(cnt_q)));
endmodule

// File: rtl/fan_override.sv
module fan_override #(
  parameter int SPD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trip,
  input  logic [SPD_W-1:0] fan_code_in,
  input  logic             fan_off_cfg,
  output logic             therm_a_n,
  output logic             therm_b_n,
  output logic [SPD_W-1:0] fan_code_out,
  output logic             fan_off_n
);
  localparam logic [SPD_W-1:0] FULL = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      therm_a_n    <= 1'b1;
      therm_b_n    <= 1'b1;
      fan_code_out <= '0;
      fan_off_n    <= 1'b1;
    end else begin
      therm_a_n    <= ~trip;
      therm_b_n    <= ~trip;
      fan_code_out <= trip ? FULL : fan_code_in;
      fan_off_n    <= trip ? 1'b1 : ~fan_off_cfg;
    end
  end

  assert_outputs_paired_R5: assert property (@(posedge clk) disable iff (rst)
    therm_a_n == therm_b_n);

  assert_trip_asserts_R5: assert property (@(posedge clk) disable iff (rst)
    trip |=> (!therm_a_n && !therm_b_n));

  assert_full_speed_R7: assert property (@(posedge clk) disable iff (rst)
    trip |=> (fan_code_out == FULL && fan_off_n));

  assert_pass_through_R8: assert property (@(posedge clk) disable iff (rst)
    !trip |=> (fan_code_out == $past(fan_code_in) && fan_off_n == !$past(fan_off_cfg)));
endmodule

// File: rtl/thermal_trip_override.sv
module thermal_trip_override
  import thermal_trip_pkg::*;
#(
  parameter int TEMP_W   = 8,
  parameter int SPD_W    = 8,
  parameter int TRIP_CNT = 3,
  parameter int HYST     = 5,
  parameter int DEF_INT  = 70,
  parameter int DEF_REM  = 100,
  parameter int RST_INT  = 127,
  parameter int RST_REM  = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hard_rst_a,
  input  logic              hard_rst_b,
  input  logic              soft_rst,
  input  logic              conv_stb,
  input  logic [TEMP_W-1:0] temp_int,
  input  logic [TEMP_W-1:0] temp_rem,
  input  logic              lim_wr_int,
  input  logic              lim_wr_rem,
  input  logic [TEMP_W-1:0] lim_wr_data,
  input  logic              cfg_wr,
  input  logic              cfg_lock,
  input  logic [SPD_W-1:0]  fan_code_in,
  input  logic              fan_off_cfg,
  output logic              therm_a_n,
  output logic              therm_b_n,
  output logic [SPD_W-1:0]  fan_code_out,
  output logic              fan_off_n
);
  logic [TEMP_W-1:0] rd_arr  [NUM_CH];
  logic [TEMP_W-1:0] lim_arr [NUM_CH];
  logic [NUM_CH-1:0] trip_vec;
  logic              trip_any;

  assign rd_arr[CH_INT] = temp_int;
  assign rd_arr[CH_REM] = temp_rem;

  trip_limit_bank #(
    .TEMP_W (TEMP_W),
    .DEF_INT(DEF_INT),
    .DEF_REM(DEF_REM),
    .RST_INT(RST_INT),
    .RST_REM(RST_REM)
  ) u_limits (
    .clk        (clk),
    .rst        (rst),
    .hard_rst_a (hard_rst_a),
    .hard_rst_b (hard_rst_b),
    .soft_rst   (soft_rst),
    .lim_wr_int (lim_wr_int),
    .lim_wr_rem (lim_wr_rem),
    .lim_wr_data(lim_wr_data),
    .cfg_wr     (cfg_wr),
    .cfg_lock   (cfg_lock),
    .act_int    (lim_arr[CH_INT]),
    .act_rem    (lim_arr[CH_REM])
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    trip_hysteresis #(
      .TEMP_W  (TEMP_W),
      .TRIP_CNT(TRIP_CNT),
      .HYST    (HYST)
    ) u_hyst (
      .clk     (clk),
      .rst     (rst),
      .conv_stb(conv_stb),
      .reading (rd_arr[g]),
      .limit   (lim_arr[g]),
      .tripped (trip_vec[g])
    );
  end

  assign trip_any = |trip_vec;

  fan_override #(
    .SPD_W(SPD_W)
  ) u_override (
    .clk         (clk),
    .rst         (rst),
    .trip        (trip_any),
    .fan_code_in (fan_code_in),
    .fan_off_cfg (fan_off_cfg),
    .therm_a_n   (therm_a_n),
    .therm_b_n   (therm_b_n),
    .fan_code_out(fan_code_out),
    .fan_off_n   (fan_off_n)
  );

  assert_soft_keeps_trip_R9: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !conv_stb) |=> $stable(trip_vec));
endmodule

// File: tb/test_thermal_trip_override.sv
module test_thermal_trip_override;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hard_rst_a = 1'b0, hard_rst_b = 1'b0, soft_rst = 1'b0;
  logic       conv_stb = 1'b0;
  logic [7:0] temp_int = 8'd0, temp_rem = 8'd0;
  logic       lim_wr_int = 1'b0, lim_wr_rem = 1'b0;
  logic [7:0] lim_wr_data = 8'd0;
  logic       cfg_wr = 1'b0, cfg_lock = 1'b0;
  logic [7:0] fan_code_in = 8'h00;
  logic       fan_off_cfg = 1'b0;
  logic       therm_a_n, therm_b_n, fan_off_n;
  logic [7:0] fan_code_out;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_trip_override i_thermal_trip_override (
    .clk(clk), .rst(rst), .hard_rst_a(hard_rst_a), .hard_rst_b(hard_rst_b),
    .soft_rst(soft_rst), .conv_stb(conv_stb), .temp_int(temp_int),
    .temp_rem(temp_rem), .lim_wr_int(lim_wr_int), .lim_wr_rem(lim_wr_rem),
    .lim_wr_data(lim_wr_data), .cfg_wr(cfg_wr), .cfg_lock(cfg_lock),
    .fan_code_in(fan_code_in), .fan_off_cfg(fan_off_cfg),
    .therm_a_n(therm_a_n), .therm_b_n(therm_b_n),
    .fan_code_out(fan_code_out), .fan_off_n(fan_off_n)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_trip(string tag, logic exp_trip);
    check(tag, {31'd0, therm_a_n}, {31'd0, !exp_trip});
    check(tag, {31'd0, therm_b_n}, {31'd0, !exp_trip});
  endtask

  // One strobe; returns at the negedge after the output register updated
  task automatic conv(logic [7:0] ti, logic [7:0] tr);
    @(negedge clk);
    temp_int = ti; temp_rem = tr; conv_stb = 1'b1;
    @(negedge clk);
    conv_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr_limit(bit rem, logic [7:0] d);
    @(negedge clk);
    lim_wr_data = d; lim_wr_int = !rem; lim_wr_rem = rem;
    @(negedge clk);
    lim_wr_int = 1'b0; lim_wr_rem = 1'b0;
  endtask

  task automatic wr_cfg(logic b);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_lock = b;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_lock = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 therm_a_n in reset", {31'd0, therm_a_n}, 32'd1);
    check("R1 therm_b_n in reset", {31'd0, therm_b_n}, 32'd1);
    check("R1 fan code in reset", {24'd0, fan_code_out}, 32'h00);
    check("R1 fan_off_n in reset", {31'd0, fan_off_n}, 32'd1);
    rst = 1'b0;
    fan_code_in = 8'h33;
    @(negedge clk);
    check("R1 released after reset", {31'd0, therm_a_n}, 32'd1);
    check("R8 pass-through code", {24'd0, fan_code_out}, 32'h33);
    fan_off_cfg = 1'b1;
    @(negedge clk);
    check("R8 pass-through fan_off", {31'd0, fan_off_n}, 32'd0);
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    temp_int = 8'd120; temp_rem = 8'd120;
    repeat (10) @(negedge clk);
    check_trip("R11 hot readings without strobe", 1'b0);
    temp_int = 8'd0; temp_rem = 8'd0;
  endtask

  task automatic t_internal_default();
    wr_limit(1'b0, 8'd120);           // R2: written but not active while unlocked
    conv(8'd71, 8'd0);
    conv(8'd71, 8'd0);
    check_trip("R4 two hot readings", 1'b0);
    conv(8'd71, 8'd0);
    check_trip("R2 R4 third reading above default 70", 1'b1);
    check("R7 full speed", {24'd0, fan_code_out}, 32'hFF);
    check("R7 fan-off released", {31'd0, fan_off_n}, 32'd1);
    @(negedge clk); fan_code_in = 8'h40;
    @(negedge clk);
    check("R7 new code masked", {24'd0, fan_code_out}, 32'hFF);
    conv(8'd65, 8'd0);
    conv(8'd65, 8'd0);
    conv(8'd66, 8'd0);                // limit-4 restarts the count
    check_trip("R6 break by limit-4", 1'b1);
    conv(8'd65, 8'd0);
    conv(8'd65, 8'd0);
    check_trip("R6 two cool readings", 1'b1);
    @(negedge clk); fan_code_in = 8'h5A;   // lands with the release
    conv(8'd65, 8'd0);
    check_trip("R6 third cool reading releases", 1'b0);
    check("R8 code written during trip", {24'd0, fan_code_out}, 32'h5A);
    check("R8 fan-off restored", {31'd0, fan_off_n}, 32'd0);
  endtask

  task automatic t_remote_soft();
    fan_off_cfg = 1'b0;
    conv(8'd0, 8'd100);
    conv(8'd0, 8'd100);
    conv(8'd0, 8'd100);
    check_trip("R4 equal to limit does not count", 1'b0);
    conv(8'd0, 8'd101);
    conv(8'd0, 8'd101);
    conv(8'd0, 8'd50);
    conv(8'd0, 8'd101);
    conv(8'd0, 8'd101);
    check_trip("R4 interrupted run", 1'b0);
    conv(8'd0, 8'd101);
    check_trip("R4 remote trips", 1'b1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    @(negedge clk);
    check_trip("R9 soft reset keeps trip", 1'b1);
    conv(8'd0, 8'd95);
    conv(8'd0, 8'd95);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    check_trip("R9 still tripped after 2 cool", 1'b1);
    conv(8'd0, 8'd95);
    check_trip("R9 count kept across soft reset", 1'b0);
  endtask

  task automatic t_channel_or();
    conv(8'd71, 8'd0);
    conv(8'd71, 8'd0);
    conv(8'd71, 8'd0);
    check_trip("R5 internal alone trips", 1'b1);
    conv(8'd71, 8'd101);
    conv(8'd71, 8'd101);
    conv(8'd71, 8'd101);
    conv(8'd65, 8'd101);
    conv(8'd65, 8'd101);
    conv(8'd65, 8'd101);
    check_trip("R5 remote holds after internal released", 1'b1);
    conv(8'd65, 8'd95);
    conv(8'd65, 8'd95);
    conv(8'd65, 8'd95);
    check_trip("R5 both released", 1'b0);
  endtask

  task automatic t_lock();
    wr_limit(1'b1, 8'hF6);            // remote programmable = -10
    wr_cfg(1'b0);
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    check_trip("R3 lock write of 0 ignored", 1'b0);
    wr_cfg(1'b1);
    wr_limit(1'b1, 8'd50);            // must be ignored
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    check_trip("R10 two readings of -5", 1'b0);
    conv(8'd0, 8'hFB);
    check_trip("R3 R10 locked limit -10 trips on -5", 1'b1);
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    conv(8'd0, 8'hF2);                // -14 is not cool enough
    conv(8'd0, 8'hF1);
    conv(8'd0, 8'hF1);
    check_trip("R6 R10 -14 breaks cooling", 1'b1);
    conv(8'd0, 8'hF1);
    check_trip("R9 R10 release at -15 with locked limit", 1'b0);
    @(negedge clk); hard_rst_a = 1'b1;
    @(negedge clk); hard_rst_a = 1'b0;
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    check_trip("R3 hard reset A unlocks", 1'b0);
    wr_cfg(1'b1);
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    check_trip("R3 relocked limit kept", 1'b1);
    conv(8'd0, 8'hF1);
    conv(8'd0, 8'hF1);
    conv(8'd0, 8'hF1);
    @(negedge clk); hard_rst_b = 1'b1;
    @(negedge clk); hard_rst_b = 1'b0;
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    conv(8'd0, 8'hFB);
    check_trip("R3 hard reset B unlocks", 1'b0);
  endtask

  initial begin
    t_reset();
    t_no_strobe();
    t_internal_default();
    t_remote_soft();
    t_channel_or();
    t_lock();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule